// File: doc/BRIEF.md
# Shared Interrupt Aggregator with Edge Capture

This block gathers a group of interrupt request lines into one shared maskable request and keeps a separate non-maskable path. Each request line can be treated as a level condition or as an edge event. Per line, software chooses the mode, which input level counts as active, whether the line takes part in the shared request, and whether a noise filter is used. An edge-mode line stores a sticky pending flag that software clears by writing a one. A level-mode line is followed as it is, with nothing stored, so a line that is already active when it is unmasked raises the request at once. The shared output stays high while any enabled line is unsatisfied, so a request that arrives while the handler is servicing another line re-enters the handler.

The non-maskable input is edge-triggered. Each inactive-to-active transition sets one flag, and the flag holds until it is acknowledged. A pin that stays active cannot set the flag again until it has returned to inactive. All inputs pass through a two-flop synchroniser, and both outputs are registered. Software reaches the configuration through a plain write strobe with an address. Reads are combinational from the address.

Top module: `irq_aggregator`

## Requirements
- R1: After reset both outputs are low. The enable, mode, polarity, filter-enable, threshold and pending registers all read zero.
- R2: An enabled level-mode line with no filter asserts `irq_o` on the third rising edge after its input goes active. `irq_o` drops on the third edge after the input goes inactive.
- R3: A polarity bit of 1 makes the line active when its input is low. A polarity bit of 0 makes it active when the input is high.
- R4: A level-mode line whose input is already active when its enable bit is written to 1 asserts `irq_o` on the edge after the write edge. No input transition is needed.
- R5: In edge mode (mode bit 1), an inactive-to-active transition sets that line's pending flag on the third edge after the input change, and `irq_o` follows one edge later. The flag stays set after the input returns inactive.
- R6: Writing address 5 clears every pending flag whose data bit is 1, at the write edge. A new active edge on the same edge leaves the flag set.
- R7: `irq_o` stays high while any enabled line is level-active or edge-pending. It drops only after the last one is satisfied.
- R8: A line whose enable bit is 0 never asserts `irq_o`. In edge mode its pending flag is still captured and can be read at address 5.
- R9: With filter-enable set and threshold T ≥ 1 (address 4; 0 acts as 1), a level-mode line asserts `irq_o` T+3 edges after its input goes active. A pulse shorter than T cycles is ignored.
- R10: An inactive-to-active transition of `nmi_pin_i` sets `nmi_o` on the third edge after it. `nmi_o` stays set until an edge where `nmi_ack_i` is high clears it.
- R11: After an acknowledge, a pin held active produces no further `nmi_o`. A new flag needs the pin to go inactive and then active again.
- R12: The register map is: 0 enable, 1 mode, 2 polarity, 3 filter-enable, 4 threshold, 5 pending, 6 level view. Address 6 reads each line's synchronised, polarity-corrected (filtered where selected) level. Addresses 0 to 4 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | N_SRC | Interrupt request lines, asynchronous |
| nmi_pin_i | input | 1 | Non-maskable request, active high, asynchronous |
| nmi_ack_i | input | 1 | Acknowledge strobe that clears `nmi_o` |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | N_SRC | Write data |
| reg_rdata_o | output | N_SRC | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Shared maskable request, registered |
| nmi_o | output | 1 | Non-maskable flag, registered |

## Verification
An input change reaches the synchronised level after two edges. The unfiltered level request is due on the third edge, an edge capture shows in the pending flag on the third edge and in `irq_o` on the fourth, and the filtered request is due on edge T+3. A register write takes effect at its own edge, and `irq_o` reflects it one edge later. The bench drives on the falling edge and samples one edge before and at the exact edge each result is due, so an off-by-one latency fails a check. The vector table walks polarity, enable and level combinations with a settle time, and the directed tests pin the exact timing.

// File: rtl/irq_agg_pkg.sv
// Package: shared register addresses for the interrupt aggregator.
// Assumes a 3-bit register address bus.
package irq_agg_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_ENABLE = 3'd0,
        RA_MODE   = 3'd1,
        RA_POL    = 3'd2,
        RA_FEN    = 3'd3,
        RA_FTHR   = 3'd4,
        RA_PEND   = 3'd5,
        RA_LEVEL  = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
// Module: multi-stage flop synchroniser for a bus of independent bits.
// Assumes each bit is an unrelated asynchronous signal; no bus coherency.
module irq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Stage s: shift one flop further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[s] <= '0;
                else if (s == 0) stg_q[s] <= d_i;
                else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_src_chan.sv
// Module: one request line after synchronisation. It provides an optional
// stability filter, edge capture into a sticky pending flag, and the
// service-needed term.
// Assumes act_i is already synchronised and polarity-corrected.
module irq_src_chan #(
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_i,
    input  logic              filt_en_i,
    input  logic [FILT_W-1:0] thr_i,
    input  logic              mode_i,
    input  logic              en_i,
    input  logic              clr_i,
    output logic              lvl_o,
    output logic              pend_o,
    output logic              need_o
);
    logic [FILT_W-1:0] cnt_q;
    logic [FILT_W-1:0] thr_m1;
    logic              filt_q;
    logic              prev_q;
    logic              pend_q;
    logic              rise;

    assign thr_m1 = (thr_i == '0) ? '0 : thr_i - 1'b1;
    assign lvl_o  = filt_en_i ? filt_q : act_i;
    assign rise   = lvl_o & ~prev_q;

    // Filter: accept a new level only after it differs for thr cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
        end else if (act_i != filt_q) begin
            if (cnt_q >= thr_m1) begin
                filt_q <= act_i;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    // Edge detector history of the effective level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_o;
    end

    // Sticky pending flag: a capture wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              pend_q <= 1'b0;
        else if (rise && mode_i) pend_q <= 1'b1;
        else if (clr_i)          pend_q <= 1'b0;
    end

    assign pend_o = pend_q;
    assign need_o = en_i & (mode_i ? pend_q : lvl_o);
endmodule

// File: rtl/irq_nmi_edge.sv
// Module: non-maskable path. One flag per inactive-to-active transition,
// held until acknowledged; re-armed only by an inactive pin with the flag clear.
// Assumes pin_i is synchronised. A pin active out of reset does not fire.
module irq_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic ack_i,
    output logic flag_o
);
    logic prev_q;
    logic armed_q;
    logic flag_q;
    logic fire;

    assign fire = pin_i & ~prev_q & armed_q;

    // Pin history for edge detection; starts as "active" to block a reset-time edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_i;
    end

    // Arming: dropped on fire, restored when flag clear and pin inactive.
    always_ff @(posedge clk) begin
        if (!rst_n)                   armed_q <= 1'b0;
        else if (fire)                armed_q <= 1'b0;
        else if (!flag_q && !pin_i)   armed_q <= 1'b1;
    end

    // Flag: set on fire, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (fire)  flag_q <= 1'b1;
        else if (ack_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/irq_aggregator.sv
// Module: top of the interrupt aggregator. It synchronises the inputs, holds
// the configuration registers, instantiates one channel per line and the
// non-maskable path, and registers the shared request.
// Assumes FILT_W <= N_SRC so the threshold fits the data bus.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int FILT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             nmi_pin_i,
    input  logic             nmi_ack_i,
    input  logic             reg_we_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [N_SRC-1:0] reg_wdata_i,
    output logic [N_SRC-1:0] reg_rdata_o,
    output logic             irq_o,
    output logic             nmi_o
);
    localparam int SYNC_W = N_SRC + 1;

    logic [N_SRC-1:0]  en_q, mode_q, pol_q, fen_q;
    logic [FILT_W-1:0] thr_q;
    logic [SYNC_W-1:0] sync_q;
    logic [N_SRC-1:0]  src_s, act, lvl_vec, pend_vec, need_vec, clr_vec;
    logic              nmi_s;
    logic              irq_q;

    irq_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({nmi_pin_i, src_i}),
        .q_o   (sync_q)
    );

    assign src_s   = sync_q[N_SRC-1:0];
    assign nmi_s   = sync_q[N_SRC];
    assign act     = src_s ^ pol_q;
    assign clr_vec = (reg_we_i && reg_addr_i == RA_PEND) ? reg_wdata_i : '0;

    // Configuration registers written through the strobe port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= '0;
            pol_q  <= '0;
            fen_q  <= '0;
            thr_q  <= '0;
        end else if (reg_we_i) begin
            case (reg_addr_e'(reg_addr_i))
                RA_ENABLE: en_q   <= reg_wdata_i;
                RA_MODE:   mode_q <= reg_wdata_i;
                RA_POL:    pol_q  <= reg_wdata_i;
                RA_FEN:    fen_q  <= reg_wdata_i;
                RA_FTHR:   thr_q  <= reg_wdata_i[FILT_W-1:0];
                default:   ;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_chan
            irq_src_chan #(.FILT_W(FILT_W)) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .act_i     (act[i]),
                .filt_en_i (fen_q[i]),
                .thr_i     (thr_q),
                .mode_i    (mode_q[i]),
                .en_i      (en_q[i]),
                .clr_i     (clr_vec[i]),
                .lvl_o     (lvl_vec[i]),
                .pend_o    (pend_vec[i]),
                .need_o    (need_vec[i])
            );
        end
    endgenerate

    irq_nmi_edge u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (nmi_s),
        .ack_i  (nmi_ack_i),
        .flag_o (nmi_o)
    );

    // Shared request: high while any enabled line is unsatisfied.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |need_vec;
    end

    assign irq_o = irq_q;

    // Read mux for the register view.
    always_comb begin
        case (reg_addr_e'(reg_addr_i))
            RA_ENABLE: reg_rdata_o = en_q;
            RA_MODE:   reg_rdata_o = mode_q;
            RA_POL:    reg_rdata_o = pol_q;
            RA_FEN:    reg_rdata_o = fen_q;
            RA_FTHR:   reg_rdata_o = N_SRC'(thr_q);
            RA_PEND:   reg_rdata_o = pend_vec;
            RA_LEVEL:  reg_rdata_o = lvl_vec;
            default:   reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
// Module: assertion checker bound to irq_aggregator. It relates the outputs
// to the register state and the input pins over time.
// Assumes a synchronous active-low reset.
module irq_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_o,
    input logic              nmi_o,
    input logic              nmi_pin_i,
    input logic              nmi_ack_i,
    input logic              reg_we_i,
    input logic [REG_AW-1:0] reg_addr_i,
    input logic [N_SRC-1:0]  en_q,
    input logic [N_SRC-1:0]  pend_vec
);
    // R8: with every enable bit clear, the shared request stays low.
    p_irq_off_when_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_q) == '0) |-> !irq_o);

    // R7: the shared request can only rise after some line was enabled.
    p_irq_rise_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(en_q) != '0));

    // R6: a pending flag falls only after a write to the pending address.
    p_pend_clear_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_vec) & ~pend_vec) != '0) |-> $past(reg_we_i && reg_addr_i == RA_PEND));

    // R10: the non-maskable flag holds until acknowledged.
    p_nmi_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_o && !nmi_ack_i) |=> nmi_o);

    // R11: the non-maskable flag rises only when the pin was active two edges before.
    p_nmi_from_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_o) |-> $past(nmi_pin_i, 2));
endmodule

bind irq_aggregator irq_aggregator_chk #(.N_SRC(N_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_o      (irq_o),
    .nmi_o      (nmi_o),
    .nmi_pin_i  (nmi_pin_i),
    .nmi_ack_i  (nmi_ack_i),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .en_q       (en_q),
    .pend_vec   (pend_vec)
);

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;
    localparam int N = 8;
    localparam int FW = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic         nmi_pin = 1'b0;
    logic         nmi_ack = 1'b0;
    logic         we = 1'b0;
    logic [2:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq, nmi;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;  // 50 MHz

    irq_aggregator #(.N_SRC(N), .FILT_W(FW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .nmi_pin_i   (nmi_pin),
        .nmi_ack_i   (nmi_ack),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .nmi_o       (nmi)
    );

    // Level-mode table for line 0: {polarity, input, enable, expected irq}
    typedef struct packed {
        logic pol;
        logic s;
        logic en;
        logic exp;
    } vec_t;
    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0}, '{1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b1, 1'b0, 1'b0}, '{1'b0, 1'b1, 1'b1, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b0}, '{1'b1, 1'b0, 1'b1, 1'b1},
        '{1'b1, 1'b1, 1'b0, 1'b0}, '{1'b1, 1'b1, 1'b1, 1'b0}
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin : watchdog
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [N-1:0] rv;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        chk("R1 irq", irq, 0);
        chk("R1 nmi", nmi, 0);
        rd(3'd0, rv); chk("R1 enable", rv, 0);
        rd(3'd1, rv); chk("R1 mode", rv, 0);
        rd(3'd2, rv); chk("R1 polarity", rv, 0);
        rd(3'd4, rv); chk("R1 threshold", rv, 0);
        rd(3'd5, rv); chk("R1 pending", rv, 0);

        // Table walk: R2 R3 R8 on line 0 in level mode
        for (int k = 0; k < 8; k++) begin
            wr(3'd2, {7'd0, VECS[k].pol});
            wr(3'd0, {7'd0, VECS[k].en});
            src[0] = VECS[k].s;
            tick(5);
            chk($sformatf("R3 table %0d", k), irq, VECS[k].exp);
        end
        wr(3'd0, '0); wr(3'd2, '0); src = '0; tick(5);

        // R2: exact level latency
        wr(3'd0, 8'h01);
        src[0] = 1'b1;
        tick(2); chk("R2 early", irq, 0);
        tick(1); chk("R2 due", irq, 1);
        src[0] = 1'b0;
        tick(2); chk("R2 hold", irq, 1);
        tick(1); chk("R2 drop", irq, 0);

        // R4 and R8: line already active, then unmasked
        wr(3'd0, 8'h00);
        src[1] = 1'b1;
        tick(5); chk("R8 masked", irq, 0);
        wr(3'd0, 8'h02);
        chk("R4 write edge", irq, 0);
        tick(1); chk("R4 unmask", irq, 1);
        src[1] = 1'b0; wr(3'd0, 8'h00); tick(4);

        // R5: edge capture on line 2
        wr(3'd1, 8'h04);
        wr(3'd0, 8'h04);
        src[2] = 1'b1; tick(1); src[2] = 1'b0;
        tick(2); chk("R5 early", irq, 0);
        tick(1); chk("R5 due", irq, 1);
        rd(3'd5, rv); chk("R5 pending", rv, 8'h04);
        tick(5); chk("R5 sticky", irq, 1);

        // R6: write-one-to-clear
        wr(3'd5, 8'h04);
        rd(3'd5, rv); chk("R6 cleared", rv, 0);
        tick(1); chk("R6 irq drop", irq, 0);

        // R6: clear colliding with a new edge keeps the flag
        src[2] = 1'b1; tick(1); src[2] = 1'b0; tick(5);
        src[2] = 1'b1; tick(2);
        wr(3'd5, 8'h04);
        rd(3'd5, rv); chk("R6 set wins", rv, 8'h04);
        src[2] = 1'b0; tick(3);
        wr(3'd5, 8'h04); tick(2);

        // R8: disabled edge line still captures
        wr(3'd0, 8'h00);
        src[2] = 1'b1; tick(1); src[2] = 1'b0; tick(6);
        chk("R8 irq off", irq, 0);
        rd(3'd5, rv); chk("R8 captured", rv, 8'h04);
        wr(3'd5, 8'hFF); tick(2);

        // R7: late arrival keeps irq high until the last line is satisfied
        wr(3'd0, 8'h05);
        src[0] = 1'b1; tick(4); chk("R7 first", irq, 1);
        src[2] = 1'b1; tick(1); src[2] = 1'b0; tick(4);
        src[0] = 1'b0; tick(6); chk("R7 still pending", irq, 1);
        wr(3'd5, 8'h04); tick(1); chk("R7 all satisfied", irq, 0);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);

        // R9: filter on line 3, threshold 4
        wr(3'd4, 8'h04);
        wr(3'd3, 8'h08);
        rd(3'd4, rv); chk("R12 threshold readback", rv, 8'h04);
        wr(3'd0, 8'h08);
        src[3] = 1'b1; tick(2); src[3] = 1'b0;
        tick(8); chk("R9 short pulse ignored", irq, 0);
        src[3] = 1'b1;
        tick(6); chk("R9 early", irq, 0);
        tick(1); chk("R9 due", irq, 1);
        src[3] = 1'b0; tick(10);
        chk("R9 release", irq, 0);
        wr(3'd0, 8'h00); wr(3'd3, 8'h00);

        // R12: readback and level view with polarity
        wr(3'd1, 8'h55);
        rd(3'd1, rv); chk("R12 mode readback", rv, 8'h55);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h0F);
        src = 8'h30;
        tick(3);
        rd(3'd6, rv); chk("R12 level view", rv, 8'h3F);
        chk("R12 disabled irq", irq, 0);
        src = '0; wr(3'd2, 8'h00); tick(3);

        // R10: NMI latency and hold
        nmi_pin = 1'b1;
        tick(2); chk("R10 early", nmi, 0);
        tick(1); chk("R10 due", nmi, 1);
        tick(5); chk("R10 hold", nmi, 1);
        nmi_ack = 1'b1; tick(1); nmi_ack = 1'b0;
        chk("R10 ack", nmi, 0);

        // R11: stuck pin does not re-fire; re-arm after inactive
        tick(10); chk("R11 stuck", nmi, 0);
        nmi_pin = 1'b0; tick(4);
        chk("R11 idle", nmi, 0);
        nmi_pin = 1'b1; tick(3); chk("R11 re-fire", nmi, 1);
        nmi_ack = 1'b1; tick(1); nmi_ack = 1'b0; nmi_pin = 1'b0;
        tick(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule